// File: doc/BRIEF.md
# Fuse-Programmable AND-OR Logic Array

This block is a sum-of-products engine with a programmable AND plane and a fixed OR plane. Every array input is offered to each product term twice, once as itself and once inverted. Each crosspoint between a product term and one of those lines holds one configuration bit. An intact crosspoint (bit value 1) pulls the line into the AND. A blown crosspoint (bit value 0) reads as a constant 1, so that line stops affecting the term. After reset every crosspoint is intact. Each term then contains some signal together with its own inverse, and it evaluates to 0.

Each output owns a fixed group of product terms that no other output can use. The OR of that group is driven out inverted, so the output is active-low. One extra term per output acts as that pin's three-state enable. The outputs are registered. A number of the outputs also loop back into the array as inputs. When such an output is disabled, the looped-back value is taken from an external pin input instead, so a design can give up an output to gain an input.

The configuration is loaded one product-term row at a time. Loading is accepted only while a program-enable input is high, and all outputs are held disabled during that time.

Top module: `sop_array`

## Requirements
- R1: While `rst` is high at a clock edge, every crosspoint becomes intact, `out_en` goes to all 0 and `out_n` goes to all 1.
- R2: Array line i is `in_pins[i]` for i < N_IN, and line N_IN+k is the feedback of output k. Configuration bit `term*(2*N_LINES) + 2*line + pol` belongs to that term and line, with pol 0 for the line itself and pol 1 for its inverse. Within a row of `wr_row`, bit 2*line+pol is that crosspoint, and bit value 1 means intact.
- R3: A blown crosspoint acts as a constant 1, so a term with every crosspoint blown evaluates to 1.
- R4: A term with every crosspoint intact, as after reset, evaluates to 0 and adds nothing to its output's sum.
- R5: Output o owns sum terms o*(N_SUM+1)+0 through o*(N_SUM+1)+N_SUM-1, and its enable term is o*(N_SUM+1)+N_SUM. A term affects no other output.
- R6: At each clock edge, `out_n[o]` takes the inverse of the OR of output o's sum terms, evaluated on the inputs present before that edge.
- R7: At each clock edge with `prog_en` low, `out_en[o]` takes the value of output o's enable term.
- R8: For k < N_FB, the feedback line of output k equals the registered `out_n[k]` while `out_en[k]` is 1, and equals `pin_in[k]` while `out_en[k]` is 0. `pin_in[k]` has no effect while that output is enabled.
- R9: A clock edge with `prog_en` and `wr_en` both high replaces row `wr_term` with `wr_row`. Terms evaluated at that same edge still use the old row. With `prog_en` low, `wr_en` has no effect.
- R10: At every clock edge with `prog_en` high, `out_en` goes to all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array |
| prog_en | input | 1 | Program enable; permits row loading and disables the outputs |
| wr_en | input | 1 | Row write strobe |
| wr_term | input | TW (6) | Index of the product term to load |
| wr_row | input | 2*N_LINES (32) | Crosspoint bits of the row; 1 means intact |
| in_pins | input | N_IN (10) | Primary inputs |
| pin_in | input | N_FB (6) | Values at the external pins of the looped-back outputs |
| out_n | output | N_OUT (8) | Registered active-low sum-of-products outputs |
| out_en | output | N_OUT (8) | Registered three-state enables of the outputs |

## Verification
`out_n` and `out_en` are due one clock edge after the inputs that produce them. A row write affects evaluation at the edge after the write, not at the write edge itself. The bench drives all inputs on the falling edge and advances its model once per rising edge, from the inputs and model state that were present before that edge. It compares both output vectors on the next falling edge, exactly one register stage later. Feedback is modelled from the bench's own previous expected outputs, so chains through the looped-back outputs keep the same one-edge-per-pass timing.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_COMP = 1'b1
  } line_pol_e;

  // Flat position of one crosspoint in the configuration map (term-major).
  function automatic int unsigned xpoint_idx(int unsigned term, int unsigned line,
                                             line_pol_e pol, int unsigned n_lines);
    return term * (2 * n_lines) + 2 * line + ((pol == POL_COMP) ? 1 : 0);
  endfunction

endpackage

// File: rtl/sop_fuse_bank.sv
module sop_fuse_bank #(
  parameter int N_TERMS = 64,
  parameter int ROW_W   = 32,
  parameter int TW      = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       prog_en,
  input  logic                       wr_en,
  input  logic [TW-1:0]              wr_term,
  input  logic [ROW_W-1:0]           wr_row,
  output logic [N_TERMS*ROW_W-1:0]   fuse_flat
);

  logic [ROW_W-1:0] row_q [N_TERMS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N_TERMS; r++) row_q[r] <= '1;
    end else if (prog_en && wr_en) begin
      for (int r = 0; r < N_TERMS; r++)
        if (wr_term == TW'(r)) row_q[r] <= wr_row;
    end
  end

  for (genvar r = 0; r < N_TERMS; r++) begin : g_flat
    assign fuse_flat[r*ROW_W +: ROW_W] = row_q[r];
  end

  // R9
  locked_map_chk: assert property (@(posedge clk) disable iff (rst)
    !(prog_en && wr_en) |=> $stable(fuse_flat));

endmodule

// File: rtl/sop_term.sv
module sop_term #(
  parameter int N_LINES = 16
) (
  input  logic [2*N_LINES-1:0] row,
  input  logic [N_LINES-1:0]   lines,
  output logic                 term_o
);

  logic [2*N_LINES-1:0] pair;

  for (genvar i = 0; i < N_LINES; i++) begin : g_pair
    assign pair[2*i]     = lines[i];
    assign pair[2*i + 1] = ~lines[i];
  end

  // A blown crosspoint (0) forces its position to 1.
  assign term_o = &(pair | ~row);

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell #(
  parameter int N_SUM = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_en,
  input  logic [N_SUM-1:0] sum_terms,
  input  logic             en_term,
  output logic             out_n_q,
  output logic             out_en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_n_q  <= 1'b1;
      out_en_q <= 1'b0;
    end else begin
      out_n_q  <= ~(|sum_terms);
      out_en_q <= en_term & ~prog_en;
    end
  end

  // R10
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    prog_en |=> !out_en_q);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_n_q && !out_en_q));

endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N_IN  = 10,
  parameter int N_OUT = 8,
  parameter int N_FB  = 6,
  parameter int N_SUM = 7,
  localparam int N_LINES = N_IN + N_FB,
  localparam int ROW_W   = 2 * N_LINES,
  localparam int TPO     = N_SUM + 1,
  localparam int N_TERMS = N_OUT * TPO,
  localparam int TW      = $clog2(N_TERMS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_en,
  input  logic             wr_en,
  input  logic [TW-1:0]    wr_term,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [N_IN-1:0]  in_pins,
  input  logic [N_FB-1:0]  pin_in,
  output logic [N_OUT-1:0] out_n,
  output logic [N_OUT-1:0] out_en
);

  logic [N_TERMS*ROW_W-1:0] fuse_flat;
  logic [N_LINES-1:0]       lines;
  logic [N_TERMS-1:0]       term_v;

  sop_fuse_bank #(.N_TERMS(N_TERMS), .ROW_W(ROW_W), .TW(TW)) u_bank (
    .clk(clk), .rst(rst), .prog_en(prog_en), .wr_en(wr_en),
    .wr_term(wr_term), .wr_row(wr_row), .fuse_flat(fuse_flat)
  );

  assign lines[N_IN-1:0] = in_pins;
  for (genvar k = 0; k < N_FB; k++) begin : g_fb
    assign lines[N_IN + k] = out_en[k] ? out_n[k] : pin_in[k];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    localparam int BASE = xpoint_idx(t, 0, POL_TRUE, N_LINES);
    sop_term #(.N_LINES(N_LINES)) u_term (
      .row(fuse_flat[BASE +: ROW_W]), .lines(lines), .term_o(term_v[t])
    );

    // R4
    erased_term_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (fuse_flat[BASE +: ROW_W] == '1) |-> !term_v[t]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    sop_out_cell #(.N_SUM(N_SUM)) u_cell (
      .clk(clk), .rst(rst), .prog_en(prog_en),
      .sum_terms(term_v[o*TPO +: N_SUM]), .en_term(term_v[o*TPO + N_SUM]),
      .out_n_q(out_n[o]), .out_en_q(out_en[o])
    );
  end

endmodule

// File: tb/sop_array_tb_top.sv
module sop_array_tb_top;
  localparam int NI = 10, NO = 8, NF = 6, NS = 7;
  localparam int NL = NI + NF, RW = 2 * NL, TPO = NS + 1, NT = NO * TPO;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, prog_en, wr_en;
  logic [5:0] wr_term;
  logic [RW-1:0] wr_row;
  logic [NI-1:0] in_pins;
  logic [NF-1:0] pin_in;
  logic [NO-1:0] out_n, out_en;

  sop_array dut_i (
    .clk(clk), .rst(rst), .prog_en(prog_en), .wr_en(wr_en), .wr_term(wr_term),
    .wr_row(wr_row), .in_pins(in_pins), .pin_in(pin_in), .out_n(out_n), .out_en(out_en)
  );

  logic [RW-1:0] fz [NT];
  logic [NO-1:0] m_n, m_en;
  int n_cmp = 0, n_bad = 0;

  function automatic logic eval_term(logic [RW-1:0] row, logic [NL-1:0] ln);
    logic r = 1'b1;
    for (int i = 0; i < NL; i++) begin
      if (row[2*i])     r = r & ln[i];
      if (row[2*i + 1]) r = r & ~ln[i];
    end
    return r;
  endfunction

  task automatic tick();
    logic [NL-1:0] ln;
    logic [NO-1:0] nn, ne;
    ln[NI-1:0] = in_pins;
    for (int k = 0; k < NF; k++) ln[NI + k] = m_en[k] ? m_n[k] : pin_in[k];
    for (int o = 0; o < NO; o++) begin
      logic s = 1'b0;
      for (int t = 0; t < NS; t++) s = s | eval_term(fz[o*TPO + t], ln);
      nn[o] = ~s;
      ne[o] = eval_term(fz[o*TPO + NS], ln) & ~prog_en;
    end
    if (prog_en && wr_en) fz[wr_term] = wr_row;
    @(posedge clk);
    @(negedge clk);
    m_n = nn;
    m_en = ne;
  endtask

  task automatic chk(string req, logic [NO-1:0] got, logic [NO-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_both(string req);
    chk({req, " out_n"}, out_n, m_n);
    chk({req, " out_en"}, out_en, m_en);
  endtask

  task automatic load(int t, logic [RW-1:0] row);
    prog_en = 1'b1; wr_en = 1'b1; wr_term = 6'(t); wr_row = row;
    tick();
    chk("R10 enables off while programming", out_en, '0);
    wr_en = 1'b0;
  endtask

  task automatic run_mode();
    prog_en = 1'b0; wr_en = 1'b0;
    tick();
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4650));
    rst = 1'b1; prog_en = 1'b0; wr_en = 1'b0; wr_term = '0; wr_row = '0;
    in_pins = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < NT; t++) fz[t] = '1;
    m_n = '1; m_en = '0;
    chk("R1 reset out_n", out_n, '1);
    chk("R1 reset out_en", out_en, '0);

    // R4: erased array keeps every term at 0 under any input
    for (int i = 0; i < 4; i++) begin
      in_pins = NI'($urandom); pin_in = NF'($urandom);
      tick();
      chk("R4 erased out_n", out_n, '1);
      chk("R4 erased out_en", out_en, '0);
    end

    // R3/R5: all-blown sum term 0 of output 0 and its enable term
    load(0, '0);
    load(NS, '0);
    run_mode();
    chk("R3 blown term drives out_n[0] low", out_n, 8'hFE);
    chk("R7 enable term of output 0", out_en, 8'h01);

    // R2: output 1 = ~in2 (true line), output 2 = in3 (complement line)
    load(1*TPO, RW'(1) << (2*2));
    load(1*TPO + NS, '0);
    load(2*TPO, RW'(1) << (2*3 + 1));
    load(2*TPO + NS, '0);
    in_pins = 10'b00_0000_0100;
    run_mode();
    chk_both("R2 in2=1 in3=0");
    in_pins = 10'b00_0000_1000;
    tick();
    chk_both("R2 in2=0 in3=1");
    chk("R5 other outputs untouched", out_n & 8'hF8, 8'hF8);

    // R9: write while prog_en low is ignored (row 8 would force out_n[1] low)
    wr_en = 1'b1; wr_term = 6'(1*TPO); wr_row = '0;
    tick();
    wr_en = 1'b0;
    tick();
    chk("R9 ignored write, out_n[1]", {7'd0, out_n[1]}, 8'd1);

    // R8: output 3 uses feedback of enabled output 0; output 5 uses pin of disabled output 4
    load(3*TPO, RW'(1) << (2*(NI + 0)));
    load(3*TPO + NS, '0);
    load(5*TPO, RW'(1) << (2*(NI + 4)));
    load(5*TPO + NS, '0);
    pin_in = 6'b01_0001;
    run_mode();
    tick();
    chk_both("R8 pin of disabled output used");
    chk("R8 out_n[5] follows pin_in[4]=1", {7'd0, out_n[5]}, 8'd0);
    chk("R8 out_n[3] ignores pin_in[0]", {7'd0, out_n[3]}, 8'd1);
    pin_in = 6'b00_0000;
    tick();
    chk_both("R8 pin toggled");
    chk("R8 out_n[5] follows pin_in[4]=0", {7'd0, out_n[5]}, 8'd1);

    // Random sparse map, then random stimulus (R6, R7, R8)
    for (int t = 0; t < NT; t++) begin
      logic [RW-1:0] r = RW'($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 8) == 0) r = '1;
      load(t, r);
    end
    run_mode();
    for (int i = 0; i < 400; i++) begin
      in_pins = NI'($urandom); pin_in = NF'($urandom);
      if (($urandom % 50) == 0) prog_en = 1'b1; else prog_en = 1'b0;
      tick();
      chk_both("R6/R7/R8 random");
    end
    prog_en = 1'b0;
    tick();
    chk_both("R6/R7 after random");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule